// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block is the exception bookkeeping for a five-stage in-order pipeline: fetch, decode, execute, memory and write-back. It owns the fetch PC and the control part of each staging register: a valid bit, the instruction's PC, an exception code and the two write enables. Fault detectors in fetch, decode, execute and memory report a code for the instruction currently in their stage. A code of zero means "no fault".

The block does not act on a fault when it is detected. It records the code in the faulting instruction's staging field and clears that instruction's write enables. It takes the exception at one place only, the end of the memory stage. In that cycle it does four things: it captures the instruction's PC and code, turns every younger instruction into a bubble, stops the faulting instruction from reaching write-back, and sends fetch to a fixed handler address.

Because every fault waits until its instruction reaches the memory stage, the oldest faulting instruction is always the one reported. This holds even when a younger instruction detected its fault earlier in time. The result is a precise exception. Every instruction older than the faulting one finishes its writes, and neither the faulting instruction nor any younger one writes anything.

Top module: `exc_commit_ctrl`

## Requirements
- R1: While reset is held, `pc_o` equals BOOT_PC, `wb_valid_o`, `mem_we_o`, `wb_reg_we_o` and `exc_taken_o` are 0, and `epc_o` and `cause_o` are 0.
- R2: With no exception taken, `pc_o` rises by STEP bytes each cycle. The instruction fetched in cycle n is in the memory stage in cycle n+3 (`mem_pc_o`) and in write-back in cycle n+4 (`wb_pc_o`).
- R3: A non-zero code on `if_exc_i`, `id_exc_i`, `ex_exc_i` or `mem_exc_i` is recorded against the instruction currently in that stage (fetch, decode, execute, memory). A code of zero means no fault.
- R4: Once an instruction holds a non-zero code, a code reported for it by a later stage is ignored. The first code is the one reported.
- R5: `exc_taken_o` is high in exactly one cycle: the cycle in which the faulting instruction is in the memory stage. This holds whichever stage detected the fault.
- R6: At the clock edge ending the cycle with `exc_taken_o` high, `epc_o` takes the faulting instruction's PC and `cause_o` takes its code. Both then hold until the next exception.
- R7: In the cycle after `exc_taken_o`, `pc_o` equals HANDLER_PC.
- R8: The instructions in fetch, decode and execute when the exception is taken never write. `wb_valid_o` stays 0 for the four cycles that follow the exception.
- R9: The faulting instruction drives neither `mem_we_o` nor `wb_reg_we_o`.
- R10: Every instruction older than the faulting one completes its memory write and its register write.
- R11: When two instructions fault, the older one is reported. This holds even if the younger one's fault was detected in an earlier cycle.
- R12: With no fault, `mem_we_o` in an instruction's memory cycle and `wb_reg_we_o` in its write-back cycle equal the `id_mem_we_i` and `id_reg_we_i` values given for it in its decode cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_exc_i | input | CW | Fault code for the instruction being fetched |
| id_exc_i | input | CW | Fault code for the instruction in decode |
| ex_exc_i | input | CW | Fault code for the instruction in execute |
| mem_exc_i | input | CW | Fault code for the instruction in the memory stage |
| id_reg_we_i | input | 1 | Decoded register-write enable of the decode instruction |
| id_mem_we_i | input | 1 | Decoded memory-write enable of the decode instruction |
| pc_o | output | AW | Fetch PC |
| mem_we_o | output | 1 | Memory write strobe, suppressed for a faulting instruction |
| mem_pc_o | output | AW | PC of the memory-stage instruction |
| wb_valid_o | output | 1 | Write-back stage holds a live instruction |
| wb_reg_we_o | output | 1 | Register-file write strobe |
| wb_pc_o | output | AW | PC of the write-back instruction |
| exc_taken_o | output | 1 | Exception committed this cycle |
| epc_o | output | AW | Saved PC of the last excepting instruction |
| cause_o | output | CW | Code of the last exception |

## Verification
The assertions assume that the detectors only report a fault for an instruction that actually occupies their stage. They also assume the pipeline never stalls, so each instruction spends exactly one cycle per stage, and that reset is released between clock edges. The stimulus stays within these limits. It tracks the position of every instruction by counting cycles from the release of reset. It injects faults only in cycles up to and including the commit cycle, so no fault is ever aimed at a flushed slot. The bench then stops each run before the handler's first instruction reaches the memory stage.

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 4,
  parameter int unsigned STEP = 4,
  parameter logic [AW-1:0] BOOT_PC = AW'('h1000),
  parameter logic [AW-1:0] HANDLER_PC = AW'('h80)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] if_exc_i,
  input  logic [CW-1:0] id_exc_i,
  input  logic [CW-1:0] ex_exc_i,
  input  logic [CW-1:0] mem_exc_i,
  input  logic          id_reg_we_i,
  input  logic          id_mem_we_i,
  output logic [AW-1:0] pc_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_pc_o,
  output logic          wb_valid_o,
  output logic          wb_reg_we_o,
  output logic [AW-1:0] wb_pc_o,
  output logic          exc_taken_o,
  output logic [AW-1:0] epc_o,
  output logic [CW-1:0] cause_o
);

  localparam logic [CW-1:0] NO_FAULT = '0;

  logic [AW-1:0] pc_q;

  logic          d_v;
  logic [AW-1:0] d_pc;
  logic [CW-1:0] d_exc;

  logic          e_v, e_rwe, e_mwe;
  logic [AW-1:0] e_pc;
  logic [CW-1:0] e_exc;

  logic          m_v, m_rwe, m_mwe;
  logic [AW-1:0] m_pc;
  logic [CW-1:0] m_exc;

  logic          w_v, w_rwe;
  logic [AW-1:0] w_pc;

  logic [AW-1:0] epc_q;
  logic [CW-1:0] cause_q;

  logic [CW-1:0] d_code, e_code, m_code;
  logic          take;

  // first recorded code wins; a later stage only fills an empty field
  assign d_code = (d_exc != NO_FAULT) ? d_exc : id_exc_i;
  assign e_code = (e_exc != NO_FAULT) ? e_exc : ex_exc_i;
  assign m_code = (m_exc != NO_FAULT) ? m_exc : mem_exc_i;

  assign take = m_v && (m_code != NO_FAULT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= BOOT_PC;
      d_v     <= 1'b0;
      d_pc    <= '0;
      d_exc   <= NO_FAULT;
      e_v     <= 1'b0;
      e_pc    <= '0;
      e_exc   <= NO_FAULT;
      e_rwe   <= 1'b0;
      e_mwe   <= 1'b0;
      m_v     <= 1'b0;
      m_pc    <= '0;
      m_exc   <= NO_FAULT;
      m_rwe   <= 1'b0;
      m_mwe   <= 1'b0;
      w_v     <= 1'b0;
      w_pc    <= '0;
      w_rwe   <= 1'b0;
      epc_q   <= '0;
      cause_q <= NO_FAULT;
    end else begin
      pc_q  <= take ? HANDLER_PC : pc_q + AW'(STEP);

      d_v   <= !take;
      d_pc  <= pc_q;
      d_exc <= if_exc_i;

      e_v   <= d_v && !take;
      e_pc  <= d_pc;
      e_exc <= d_code;
      e_rwe <= id_reg_we_i && (d_code == NO_FAULT);
      e_mwe <= id_mem_we_i && (d_code == NO_FAULT);

      m_v   <= e_v && !take;
      m_pc  <= e_pc;
      m_exc <= e_code;
      m_rwe <= e_rwe && (e_code == NO_FAULT);
      m_mwe <= e_mwe && (e_code == NO_FAULT);

      w_v   <= m_v && !take;
      w_pc  <= m_pc;
      w_rwe <= m_rwe && (m_code == NO_FAULT);

      if (take) begin
        epc_q   <= m_pc;
        cause_q <= m_code;
      end
    end
  end

  assign pc_o        = pc_q;
  assign mem_we_o    = m_v && m_mwe && (m_code == NO_FAULT);
  assign mem_pc_o    = m_pc;
  assign wb_valid_o  = w_v;
  assign wb_reg_we_o = w_v && w_rwe;
  assign wb_pc_o     = w_pc;
  assign exc_taken_o = take;
  assign epc_o       = epc_q;
  assign cause_o     = cause_q;

endmodule

// File: rtl/exc_commit_ctrl_chk.sv
module exc_commit_ctrl_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 4,
  parameter int unsigned STEP = 4,
  parameter logic [AW-1:0] HANDLER_PC = AW'('h80)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_pc_o,
  input logic          wb_valid_o,
  input logic          wb_reg_we_o,
  input logic          exc_taken_o,
  input logic [AW-1:0] epc_o,
  input logic [CW-1:0] cause_o
);

  a_r2_sequential_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken_o |=> pc_o == $past(pc_o) + AW'(STEP));

  a_r7_handler_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken_o |=> pc_o == HANDLER_PC);

  a_r6_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken_o |=> epc_o == $past(mem_pc_o));

  a_r6_cause_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken_o |=> cause_o != '0);

  a_r9_no_faulting_store: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken_o |-> !mem_we_o);

  a_r8_no_writeback_after: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken_o |=> !wb_valid_o && !wb_reg_we_o);

  a_r6_epc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken_o |=> $stable(epc_o) && $stable(cause_o));

endmodule

bind exc_commit_ctrl exc_commit_ctrl_chk #(
  .AW(AW), .CW(CW), .STEP(STEP), .HANDLER_PC(HANDLER_PC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .mem_we_o(mem_we_o),
  .mem_pc_o(mem_pc_o), .wb_valid_o(wb_valid_o), .wb_reg_we_o(wb_reg_we_o),
  .exc_taken_o(exc_taken_o), .epc_o(epc_o), .cause_o(cause_o)
);

// File: tb/exc_commit_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_commit_ctrl_tb_top;

  localparam int unsigned AW = 32;
  localparam int unsigned CW = 4;
  localparam logic [31:0] BOOT = 32'h0000_1000;
  localparam logic [31:0] HND  = 32'h0000_0080;

  // idx_a, stage_a, code_a, idx_b, stage_b, code_b ; stage 0=IF 1=ID 2=EX 3=MEM
  localparam int NSC = 8;
  localparam int SCN [NSC][6] = '{
    '{2, 2, 5,  -1, 0, 0},
    '{0, 0, 1,  -1, 0, 0},
    '{4, 3, 7,  -1, 0, 0},
    '{3, 1, 2,  -1, 0, 0},
    '{5, 1, 3,   5, 3, 9},
    '{6, 3, 4,   7, 0, 6},
    '{4, 2, 8,   5, 1, 10},
    '{1, 3, 15,  2, 0, 11}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] if_exc, id_exc, ex_exc, mem_exc;
  logic          id_rwe, id_mwe;
  logic [AW-1:0] pc_o, mem_pc_o, wb_pc_o, epc_o;
  logic          mem_we_o, wb_valid_o, wb_reg_we_o, exc_taken_o;
  logic [CW-1:0] cause_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  exc_commit_ctrl #(.AW(AW), .CW(CW), .STEP(4), .BOOT_PC(BOOT), .HANDLER_PC(HND)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .if_exc_i(if_exc), .id_exc_i(id_exc), .ex_exc_i(ex_exc), .mem_exc_i(mem_exc),
    .id_reg_we_i(id_rwe), .id_mem_we_i(id_mwe),
    .pc_o(pc_o), .mem_we_o(mem_we_o), .mem_pc_o(mem_pc_o),
    .wb_valid_o(wb_valid_o), .wb_reg_we_o(wb_reg_we_o), .wb_pc_o(wb_pc_o),
    .exc_taken_o(exc_taken_o), .epc_o(epc_o), .cause_o(cause_o)
  );

  function automatic logic [31:0] pcof(int k);
    return BOOT + 32'(4 * k);
  endfunction
  function automatic logic mwe_of(int k);
    return (k % 2) == 0;
  endfunction
  function automatic logic rwe_of(int k);
    return (k % 3) != 2;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    if_exc = '0; id_exc = '0; ex_exc = '0; mem_exc = '0;
    id_rwe = 1'b0; id_mwe = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 reset state",
        {pc_o, 7'd0, wb_valid_o, mem_we_o, wb_reg_we_o, exc_taken_o, cause_o, 12'd0},
        {BOOT, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 12'd0});
    chk("R1 epc reset", {32'd0, epc_o}, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic run_scn(int ia, int sa, int ca, int ib, int sb, int cb);
    int win, wcode, last;
    int taken_n, taken_at, mw, rw, yw, seq_bad, bub_bad, pc_after;
    int exp_mw, exp_rw;
    win = ia; wcode = ca;
    if (ib >= 0 && (ib < ia || (ib == ia && sb < sa))) begin win = ib; wcode = cb; end
    last = win + 6;
    taken_n = 0; taken_at = -1; mw = 0; rw = 0; yw = 0; seq_bad = 0; bub_bad = 0; pc_after = 0;
    do_reset();
    for (int n = 0; n <= last; n++) begin
      if_exc = '0; id_exc = '0; ex_exc = '0; mem_exc = '0;
      if (n <= win + 3) begin
        for (int s = 0; s < 4; s++) begin
          int k;
          logic [CW-1:0] c;
          k = n - s;
          c = '0;
          if (k == ia && s == sa) c = CW'(ca);
          else if (k == ib && s == sb) c = CW'(cb);
          case (s)
            0: if_exc = c;
            1: id_exc = c;
            2: ex_exc = c;
            default: mem_exc = c;
          endcase
        end
      end
      id_rwe = (n >= 1) ? rwe_of(n - 1) : 1'b0;
      id_mwe = (n >= 1) ? mwe_of(n - 1) : 1'b0;
      #1;
      if (exc_taken_o) begin taken_n++; taken_at = n; end
      if (mem_we_o) begin
        mw++;
        if (mem_pc_o >= pcof(win)) yw++;
      end
      if (wb_reg_we_o) begin
        rw++;
        if (wb_pc_o >= pcof(win)) yw++;
      end
      if (n <= win + 3) begin
        if (pc_o !== pcof(n)) seq_bad++;
        if (n >= 4 && (wb_pc_o !== pcof(n - 4) || !wb_valid_o)) seq_bad++;
      end
      if (n == win + 4 && pc_o === HND) pc_after = 1;
      if (n >= win + 4 && wb_valid_o) bub_bad++;
      @(negedge clk);
    end
    exp_mw = 0; exp_rw = 0;
    for (int k = 0; k < win; k++) begin
      exp_mw += int'(mwe_of(k));
      exp_rw += int'(rwe_of(k));
    end
    chk("R2 sequential fetch and stage timing", 64'(seq_bad), 64'd0);
    chk("R5 single commit in memory-stage cycle", {32'(taken_n), 32'(taken_at)}, {32'd1, 32'(win + 3)});
    chk("R6 epc of oldest faulting instruction", {32'd0, epc_o}, {32'd0, pcof(win)});
    if (ib >= 0 && ib == ia)
      chk("R4 first code kept", 64'(cause_o), 64'(wcode));
    else if (ib >= 0)
      chk("R11 older instruction reported", 64'(cause_o), 64'(wcode));
    else
      chk("R3 stage code recorded as cause", 64'(cause_o), 64'(wcode));
    chk("R7 fetch redirected to handler", 64'(pc_after), 64'd1);
    chk("R8 bubbles after commit", 64'(bub_bad), 64'd0);
    chk("R9 no write from faulting or younger", 64'(yw), 64'd0);
    chk("R10 older memory writes done", 64'(mw), 64'(exp_mw));
    chk("R10 older register writes done", 64'(rw), 64'(exp_rw));
  endtask

  task automatic run_clean();
    int mw, rw, tk;
    mw = 0; rw = 0; tk = 0;
    do_reset();
    for (int n = 0; n < 12; n++) begin
      id_rwe = (n >= 1) ? rwe_of(n - 1) : 1'b0;
      id_mwe = (n >= 1) ? mwe_of(n - 1) : 1'b0;
      #1;
      if (exc_taken_o) tk++;
      if (n >= 3) begin
        if (mem_we_o !== mwe_of(n - 3)) mw++;
        if (mem_pc_o !== pcof(n - 3)) mw++;
      end
      if (n >= 4 && wb_reg_we_o !== rwe_of(n - 4)) rw++;
      @(negedge clk);
    end
    chk("R12 memory writes follow decode enable", 64'(mw), 64'd0);
    chk("R12 register writes follow decode enable", 64'(rw), 64'd0);
    chk("R3 zero codes take nothing", 64'(tk), 64'd0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    if_exc = '0; id_exc = '0; ex_exc = '0; mem_exc = '0;
    id_rwe = 1'b0; id_mwe = 1'b0;
    for (int i = 0; i < NSC; i++)
      run_scn(SCN[i][0], SCN[i][1], SCN[i][2], SCN[i][3], SCN[i][4], SCN[i][5]);
    run_clean();
    // corner: reset asserted while a fault is in flight clears everything
    do_reset();
    if_exc = 4'd6;
    @(negedge clk);
    if_exc = '0;
    @(negedge clk);
    do_reset();
    #1;
    chk("R1 reset discards pending fault", {32'(exc_taken_o), epc_o}, {32'd0, 32'd0});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule